// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged L1 Lookup

This block is the load lookup path of a first-level cache whose set is chosen by virtual address bits and whose tags hold physical page numbers. When a load is accepted, the set index is taken from bits that lie inside the 8 KB page offset. In the same cycle, a small fully associative translation buffer converts the virtual page number into a physical page number. The tag read from the selected set is then compared with that physical page number. Because the index never uses translated bits, two virtual pages that map to one physical page always land in the same set.

When the translation buffer has no entry for the page, the block stops taking loads and asks an external page-table walker for the entry. If the entry marks the page as present, the translation is installed in the least recently used slot. The access is then replayed through the lookup stage and completes as a translation hit. If the entry marks the page as absent, the block drops the access and raises a one-cycle fault pulse. A line install port writes a tag and a data word into one set; it stands in for the refill path, which is outside this block. A flush input invalidates every translation.

Top module: `vipt_lookup`

## Requirements
- R1: While reset is applied, and in the first cycle after it is released, `req_ready_o` is 1 and `resp_valid_o`, `fault_o` and `walk_req_o` are 0.
- R2: The set index is virtual address bits [11:6]. Bits [12:0] are the page offset and are never translated. Bits [31:13] form the virtual page number.
- R3: `resp_hit_o` is 1 only when the line in the indexed set is valid and its stored tag equals the physical page number from the translation. A tag equal to the virtual page number is not enough. On a miss, `resp_hit_o` is 0.
- R4: When the translation is present, `resp_valid_o` is high for one cycle, starting at the first clock edge after the edge that accepts the load. It carries the hit flag and the line data.
- R5: On a translation miss, `walk_req_o` rises at the edge after the lookup cycle and carries the virtual page number. `req_ready_o` stays 0 until the walk response is taken.
- R6: A walk response with the present flag set installs the translation. The lookup is then replayed, and the result appears one edge after the response edge. Later loads to that page issue no walk, and no page ever occupies two slots.
- R7: A walk response with the present flag cleared produces a one-cycle `fault_o` pulse with no `resp_valid_o` and installs nothing, so a repeat access walks again.
- R8: An install goes to the lowest-numbered empty slot. When no slot is empty, it goes to the least recently used slot, where both hits and installs count as uses.
- R9: A one-cycle `flush_i` pulse invalidates all translations at the next edge, so any later access walks.
- R10: Two virtual pages translated to the same physical page hit the same cached line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Invalidate all translations |
| req_valid_i | input | 1 | Load request valid |
| req_vaddr_i | input | 32 | Load virtual address |
| req_ready_o | output | 1 | Load request can be accepted |
| resp_valid_o | output | 1 | Lookup result valid |
| resp_hit_o | output | 1 | Cache hit flag |
| resp_data_o | output | 32 | Data of the indexed line |
| fault_o | output | 1 | Page not resident, access dropped |
| walk_req_o | output | 1 | Page-table entry requested |
| walk_vpn_o | output | 19 | Virtual page number to walk |
| walk_rsp_valid_i | input | 1 | Walk response valid |
| walk_rsp_ppn_i | input | 19 | Physical page number from the walk |
| walk_rsp_present_i | input | 1 | Page resident flag from the walk |
| fill_valid_i | input | 1 | Install a line |
| fill_index_i | input | 6 | Set to install |
| fill_ptag_i | input | 19 | Physical tag of the installed line |
| fill_data_i | input | 32 | Data of the installed line |

## Verification
The assertions check, on every cycle, properties that hold whatever the stimulus is: a walk in progress keeps the request port closed, a fault never comes with a response and lasts only one cycle, and a response always follows a lookup cycle. They also check that no virtual page matches two translation slots, that the recency ages stay a permutation with exactly one oldest slot, and that a flush leaves no valid translation. Other behaviours need a chosen sequence of accesses, so only the bench scenarios can show them. These are the choice of eviction victim, the physical-tag rule against a line tagged with the virtual page, sharing of one line by aliased pages, and a repeated walk after a fault or a flush.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_WALK = 2'd2
  } lk_state_e;
endpackage

// File: rtl/vipt_tlb.sv
module vipt_tlb #(
  parameter int ENTRIES = 4,
  parameter int VPN_W   = 19,
  parameter int PPN_W   = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             look_en_i,
  input  logic [VPN_W-1:0] look_vpn_i,
  output logic             hit_o,
  output logic [PPN_W-1:0] ppn_o,
  input  logic             fill_en_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PPN_W-1:0] fill_ppn_i
);
  localparam int AGE_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid_q, valid_n;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [AGE_W-1:0]   age_q [ENTRIES];
  logic [AGE_W-1:0]   age_n [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic [ENTRIES-1:0] oldest;
  logic [AGE_W-1:0]   hit_idx, victim, touch_idx;
  logic               touch_en, empty_found;

  // associative compare
  always_comb begin
    ppn_o   = '0;
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      match[i]  = valid_q[i] && (vpn_q[i] == look_vpn_i);
      oldest[i] = (age_q[i] == AGE_W'(ENTRIES - 1));
      if (match[i]) begin
        ppn_o   = ppn_o | ppn_q[i];
        hit_idx = AGE_W'(i);
      end
    end
    hit_o = |match;
  end

  // victim: first empty slot, otherwise the oldest one
  always_comb begin
    victim      = '0;
    empty_found = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!valid_q[i] && !empty_found) begin
        victim      = AGE_W'(i);
        empty_found = 1'b1;
      end
    end
    if (!empty_found) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (oldest[i]) victim = AGE_W'(i);
      end
    end
  end

  // recency update
  always_comb begin
    touch_en  = fill_en_i || (look_en_i && hit_o);
    touch_idx = fill_en_i ? victim : hit_idx;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!touch_en)                       age_n[i] = age_q[i];
      else if (AGE_W'(i) == touch_idx)     age_n[i] = '0;
      else if (age_q[i] < age_q[touch_idx]) age_n[i] = age_q[i] + 1'b1;
      else                                 age_n[i] = age_q[i];
    end
    valid_n = flush_i ? '0 : valid_q;
    if (fill_en_i) valid_n[victim] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= AGE_W'(i);
    end else begin
      valid_q <= valid_n;
      if (touch_en) begin
        for (int i = 0; i < ENTRIES; i++) age_q[i] <= age_n[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en_i) begin
      vpn_q[victim] <= fill_vpn_i;
      ppn_q[victim] <= fill_ppn_i;
    end
  end

  // R6
  tlb_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
  // R8
  lru_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest) == 1);
  // R9
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_i && !fill_en_i) |=> (valid_q == '0));
endmodule

// File: rtl/vipt_arrays.sv
module vipt_arrays #(
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 19,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [TAG_W-1:0]  cmp_tag_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] data_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0]   line_vld_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [DATA_W-1:0] data_q [SETS];

  always_comb begin
    hit_o  = line_vld_q[rd_idx_i] && (tag_q[rd_idx_i] == cmp_tag_i);
    data_o = data_q[rd_idx_i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       line_vld_q <= '0;
    else if (wr_en_i) line_vld_q[wr_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      tag_q[wr_idx_i]  <= wr_tag_i;
      data_q[wr_idx_i] <= wr_data_i;
    end
  end
endmodule

// File: rtl/vipt_ctrl.sv
module vipt_ctrl
  import vipt_pkg::*;
#(
  parameter int VPN_W  = 19,
  parameter int PPN_W  = 19,
  parameter int IDX_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic [VPN_W-1:0]  req_vpn_i,
  input  logic [IDX_W-1:0]  req_idx_i,
  output logic              req_ready_o,
  output logic              look_en_o,
  output logic [VPN_W-1:0]  look_vpn_o,
  output logic [IDX_W-1:0]  look_idx_o,
  input  logic              tlb_hit_i,
  input  logic              arr_hit_i,
  input  logic [DATA_W-1:0] arr_data_i,
  output logic              walk_req_o,
  input  logic              walk_rsp_valid_i,
  input  logic              walk_rsp_present_i,
  output logic              tlb_fill_o,
  output logic              resp_valid_o,
  output logic              resp_hit_o,
  output logic [DATA_W-1:0] resp_data_o,
  output logic              fault_o
);
  lk_state_e         state_q, state_n;
  logic [VPN_W-1:0]  vpn_q;
  logic [IDX_W-1:0]  idx_q;
  logic              accept;
  logic              rvld_n, fault_n;

  always_comb begin
    req_ready_o = (state_q == ST_IDLE) || ((state_q == ST_LOOK) && tlb_hit_i);
    accept      = req_valid_i && req_ready_o;
    look_en_o   = (state_q == ST_LOOK);
    walk_req_o  = (state_q == ST_WALK);
    tlb_fill_o  = walk_req_o && walk_rsp_valid_i && walk_rsp_present_i;
    rvld_n      = look_en_o && tlb_hit_i;
    fault_n     = walk_req_o && walk_rsp_valid_i && !walk_rsp_present_i;
    state_n     = state_q;
    case (state_q)
      ST_IDLE: if (accept) state_n = ST_LOOK;
      ST_LOOK: begin
        if (!tlb_hit_i)  state_n = ST_WALK;
        else if (!accept) state_n = ST_IDLE;
      end
      ST_WALK: if (walk_rsp_valid_i)
        state_n = walk_rsp_present_i ? ST_LOOK : ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  assign look_vpn_o = vpn_q;
  assign look_idx_o = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      resp_valid_o <= 1'b0;
      fault_o      <= 1'b0;
    end else begin
      state_q      <= state_n;
      resp_valid_o <= rvld_n;
      fault_o      <= fault_n;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      vpn_q <= req_vpn_i;
      idx_q <= req_idx_i;
    end
    if (rvld_n) begin
      resp_hit_o  <= arr_hit_i;
      resp_data_o <= arr_data_i;
    end
  end

  // R5
  walk_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req_o |-> !req_ready_o);
  // R7
  fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> !resp_valid_o);
  // R7
  fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> !fault_o);
  // R4
  resp_after_look_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid_o |-> $past(state_q == ST_LOOK));
endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int PG_W    = 13,
  parameter int OFF_W   = 6,
  parameter int IDX_W   = 6,
  parameter int DATA_W  = 32,
  parameter int TLB_N   = 4,
  localparam int VPN_W  = VA_W - PG_W,
  localparam int PPN_W  = PA_W - PG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              req_valid_i,
  input  logic [VA_W-1:0]   req_vaddr_i,
  output logic              req_ready_o,
  output logic              resp_valid_o,
  output logic              resp_hit_o,
  output logic [DATA_W-1:0] resp_data_o,
  output logic              fault_o,
  output logic              walk_req_o,
  output logic [VPN_W-1:0]  walk_vpn_o,
  input  logic              walk_rsp_valid_i,
  input  logic [PPN_W-1:0]  walk_rsp_ppn_i,
  input  logic              walk_rsp_present_i,
  input  logic              fill_valid_i,
  input  logic [IDX_W-1:0]  fill_index_i,
  input  logic [PPN_W-1:0]  fill_ptag_i,
  input  logic [DATA_W-1:0] fill_data_i
);
  localparam int IDX_LO = OFF_W;
  localparam int IDX_HI = OFF_W + IDX_W - 1;

  logic [1:0]        rst_sync_q;
  logic              rst_ns;
  logic              look_en, tlb_hit, tlb_fill, arr_hit;
  logic [VPN_W-1:0]  look_vpn;
  logic [IDX_W-1:0]  look_idx;
  logic [PPN_W-1:0]  tlb_ppn;
  logic [DATA_W-1:0] arr_data;
  logic              unused_va;

  assign unused_va = ^req_vaddr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns     = rst_sync_q[1];
  assign walk_vpn_o = look_vpn;

  vipt_ctrl #(.VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ctrl (
    .clk, .rst_n(rst_ns),
    .req_valid_i, .req_vpn_i(req_vaddr_i[VA_W-1:PG_W]),
    .req_idx_i(req_vaddr_i[IDX_HI:IDX_LO]), .req_ready_o,
    .look_en_o(look_en), .look_vpn_o(look_vpn), .look_idx_o(look_idx),
    .tlb_hit_i(tlb_hit), .arr_hit_i(arr_hit), .arr_data_i(arr_data),
    .walk_req_o, .walk_rsp_valid_i, .walk_rsp_present_i,
    .tlb_fill_o(tlb_fill),
    .resp_valid_o, .resp_hit_o, .resp_data_o, .fault_o
  );

  vipt_tlb #(.ENTRIES(TLB_N), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_tlb (
    .clk, .rst_n(rst_ns), .flush_i,
    .look_en_i(look_en), .look_vpn_i(look_vpn),
    .hit_o(tlb_hit), .ppn_o(tlb_ppn),
    .fill_en_i(tlb_fill), .fill_vpn_i(look_vpn), .fill_ppn_i(walk_rsp_ppn_i)
  );

  vipt_arrays #(.IDX_W(IDX_W), .TAG_W(PPN_W), .DATA_W(DATA_W)) u_arr (
    .clk, .rst_n(rst_ns),
    .rd_idx_i(look_idx), .cmp_tag_i(tlb_ppn),
    .hit_o(arr_hit), .data_o(arr_data),
    .wr_en_i(fill_valid_i), .wr_idx_i(fill_index_i),
    .wr_tag_i(fill_ptag_i), .wr_data_i(fill_data_i)
  );

  // R2
  index_in_offset_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (IDX_HI < PG_W));
endmodule

// File: tb/vipt_lookup_tb.sv
module vipt_lookup_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush_i, req_valid_i, walk_rsp_valid_i, walk_rsp_present_i, fill_valid_i;
  logic [31:0] req_vaddr_i, fill_data_i, resp_data_o;
  logic [18:0] walk_rsp_ppn_i, fill_ptag_i, walk_vpn_o;
  logic [5:0]  fill_index_i;
  logic        req_ready_o, resp_valid_o, resp_hit_o, fault_o, walk_req_o;
  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  vipt_lookup u_dut (
    .clk, .rst_n, .flush_i, .req_valid_i, .req_vaddr_i, .req_ready_o,
    .resp_valid_o, .resp_hit_o, .resp_data_o, .fault_o,
    .walk_req_o, .walk_vpn_o, .walk_rsp_valid_i, .walk_rsp_ppn_i, .walk_rsp_present_i,
    .fill_valid_i, .fill_index_i, .fill_ptag_i, .fill_data_i
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  function automatic logic [31:0] mkva(input logic [18:0] vpn, input logic [5:0] idx, input logic [5:0] off);
    return {vpn, 1'b0, idx, off};
  endfunction

  task automatic put_line(input logic [5:0] idx, input logic [18:0] tag, input logic [31:0] data);
    @(negedge clk);
    fill_valid_i = 1; fill_index_i = idx; fill_ptag_i = tag; fill_data_i = data;
    @(negedge clk);
    fill_valid_i = 0;
  endtask

  task automatic do_load(input string req, input logic [18:0] vpn, input logic [5:0] idx,
                         input logic [5:0] off, input bit exp_walk, input logic [18:0] ppn,
                         input bit present, input bit exp_hit, input logic [31:0] exp_data);
    @(negedge clk);
    chk(req, "ready before accept", req_ready_o, 1);
    req_valid_i = 1; req_vaddr_i = mkva(vpn, idx, off);
    @(negedge clk);
    req_valid_i = 0;
    @(negedge clk);
    if (!exp_walk) begin
      chk(req, "no walk", walk_req_o, 0);
      chk(req, "resp_valid", resp_valid_o, 1);
      chk(req, "resp_hit", resp_hit_o, exp_hit);
      if (exp_hit) chk(req, "resp_data", resp_data_o, exp_data);
    end else begin
      chk("R5", "walk_req", walk_req_o, 1);
      chk("R5", "walk_vpn", walk_vpn_o, vpn);
      chk("R5", "ready low in walk", req_ready_o, 0);
      @(negedge clk);
      chk("R5", "ready still low", req_ready_o, 0);
      walk_rsp_valid_i = 1; walk_rsp_ppn_i = ppn; walk_rsp_present_i = present;
      @(negedge clk);
      walk_rsp_valid_i = 0;
      if (present) begin
        chk("R6", "no resp in replay cycle", resp_valid_o, 0);
        @(negedge clk);
        chk("R6", "resp_valid after replay", resp_valid_o, 1);
        chk(req, "resp_hit after replay", resp_hit_o, exp_hit);
        if (exp_hit) chk(req, "resp_data after replay", resp_data_o, exp_data);
        chk("R6", "walk done", walk_req_o, 0);
      end else begin
        chk("R7", "fault pulse", fault_o, 1);
        chk("R7", "no resp with fault", resp_valid_o, 0);
        @(negedge clk);
        chk("R7", "fault ends", fault_o, 0);
        chk("R7", "ready back", req_ready_o, 1);
        chk("R7", "no resp after fault", resp_valid_o, 0);
      end
    end
  endtask

  task automatic t_reset();
    rst_n = 0; flush_i = 0; req_valid_i = 0; req_vaddr_i = '0;
    walk_rsp_valid_i = 0; walk_rsp_ppn_i = '0; walk_rsp_present_i = 0;
    fill_valid_i = 0; fill_index_i = '0; fill_ptag_i = '0; fill_data_i = '0;
    repeat (3) @(negedge clk);
    chk("R1", "ready in reset", req_ready_o, 1);
    chk("R1", "resp_valid in reset", resp_valid_o, 0);
    chk("R1", "fault in reset", fault_o, 0);
    chk("R1", "walk_req in reset", walk_req_o, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1", "ready after reset", req_ready_o, 1);
    chk("R1", "walk_req after reset", walk_req_o, 0);
  endtask

  task automatic t_basic();
    put_line(6'd5, 19'h00123, 32'hA5A5_0001);
    put_line(6'd6, 19'h00456, 32'hB6B6_0002);
    put_line(6'd7, 19'h00011, 32'hC7C7_0003);
    // R2 R6: first access walks, installs, replays into a cache hit on set 5
    do_load("R6", 19'h00010, 6'd5, 6'd0, 1, 19'h00123, 1, 1, 32'hA5A5_0001);
    // R4 R2: same page, different offset within the line, no walk
    do_load("R4", 19'h00010, 6'd5, 6'd44, 0, '0, 0, 1, 32'hA5A5_0001);
    // R2: other set of the same page misses (set 6 holds another tag)
    do_load("R2", 19'h00010, 6'd6, 6'd0, 0, '0, 0, 0, '0);
  endtask

  task automatic t_phys_tag();
    // R3: set 7 tagged with the virtual page number, translation gives another PPN
    do_load("R3", 19'h00011, 6'd7, 6'd4, 1, 19'h00222, 1, 0, '0);
  endtask

  task automatic t_alias();
    // R10: second virtual page mapped to the same physical page
    do_load("R10", 19'h00012, 6'd5, 6'd8, 1, 19'h00123, 1, 1, 32'hA5A5_0001);
  endtask

  task automatic t_fault();
    do_load("R7", 19'h00013, 6'd5, 6'd0, 1, 19'h00999, 0, 0, '0);
    // R7: nothing installed, so the repeat walks again
    do_load("R7", 19'h00013, 6'd5, 6'd0, 1, 19'h00999, 0, 0, '0);
  endtask

  task automatic t_lru();
    // R8: fourth slot taken from the empty one
    do_load("R8", 19'h00014, 6'd6, 6'd0, 1, 19'h00456, 1, 1, 32'hB6B6_0002);
    do_load("R8", 19'h00010, 6'd5, 6'd0, 0, '0, 0, 1, 32'hA5A5_0001);
    // R8: full, least recent is page 0x11
    do_load("R8", 19'h00015, 6'd5, 6'd0, 1, 19'h00777, 1, 0, '0);
    do_load("R8", 19'h00010, 6'd5, 6'd0, 0, '0, 0, 1, 32'hA5A5_0001);
    do_load("R8", 19'h00012, 6'd5, 6'd0, 0, '0, 0, 1, 32'hA5A5_0001);
    do_load("R8", 19'h00014, 6'd6, 6'd0, 0, '0, 0, 1, 32'hB6B6_0002);
    do_load("R8", 19'h00015, 6'd5, 6'd0, 0, '0, 0, 0, '0);
    do_load("R8", 19'h00011, 6'd7, 6'd0, 1, 19'h00011, 1, 1, 32'hC7C7_0003);
  endtask

  task automatic t_flush();
    @(negedge clk);
    flush_i = 1;
    @(negedge clk);
    flush_i = 0;
    // R9: every page walks after the flush
    do_load("R9", 19'h00015, 6'd5, 6'd0, 1, 19'h00123, 1, 1, 32'hA5A5_0001);
    do_load("R9", 19'h00011, 6'd7, 6'd0, 1, 19'h00011, 1, 1, 32'hC7C7_0003);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_phys_tag();
    t_alias();
    t_fault();
    t_lru();
    t_flush();
    repeat (2) @(negedge clk);
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end
endmodule